// File: doc/BRIEF.md
# Multi-mode branch direction predictor

This block guesses whether a branch will be taken. A front end presents a lookup with the branch address and a 2-bit branch kind. One clock later the block returns a registered taken/not-taken answer. A separate update port reports each resolved branch's real outcome, and that outcome trains a small per-entry history table. The table is indexed by a few low address bits.

A mode input picks one of three policies, and it can change from one lookup to the next.

- **Fixed:** the answer is always not taken.
- **Static:** the answer depends only on the branch kind.
- **Dynamic:** the table entry selected by the address holds the last three outcomes recorded for it. The answer is a majority vote over those three outcomes.

Updates train the table in every mode, so switching to dynamic mode uses history gathered earlier.

Top module: `bdir_predictor`

## Requirements
- R1: While `rst` is high and on the cycle after it, `pr_valid` and `pr_taken` are 0. Reset also clears every history entry to three not-taken outcomes, so a dynamic lookup of any entry after reset predicts not taken.
- R2: A lookup with `lk_valid`=1 sampled at a clock edge gives `pr_valid`=1 right after that edge. With `lk_valid`=0, `pr_valid` is 0 after the edge, and `pr_taken` is 0 whenever `pr_valid` is 0.
- R3: When `mode` is 2'b00 (fixed) or 2'b11 (reserved), every prediction is not taken, whatever the branch kind or history.
- R4: When `mode` is 2'b01 (static), the prediction depends only on `lk_kind`. Kind 2'b01 (conditional) is predicted not taken. Kind 2'b00 (unconditional), kind 2'b10 (loop) and kind 2'b11 (call/return) are predicted taken.
- R5: When `mode` is 2'b10 (dynamic), the prediction is taken exactly when at least two of the three outcomes held in the selected entry are taken.
- R6: An update (`up_valid`=1) shifts `up_taken` into the selected entry as its newest outcome and drops the oldest of the three outcomes. Updates are applied in every mode.
- R7: The entry is selected by address bits [5:2], giving 16 entries. Addresses that differ only in other bits share an entry. Entries with different bits [5:2] do not affect one another.
- R8: When a lookup and an update select the same entry in the same cycle, the prediction uses the history held before that update. The update still takes effect for later lookups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Policy: 00 fixed, 01 static, 10 dynamic, 11 reserved (acts as fixed) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Branch address of the lookup |
| lk_kind | input | 2 | Branch kind: 00 unconditional, 01 conditional, 10 loop, 11 call/return |
| up_valid | input | 1 | Resolved-outcome report |
| up_addr | input | 32 | Branch address of the resolved branch |
| up_taken | input | 1 | Real outcome, 1 = taken |
| pr_valid | output | 1 | Registered: a prediction is presented |
| pr_taken | output | 1 | Registered predicted direction, 1 = taken |

## Verification
A lookup and a training update can land on the same table entry in one clock. The bench provokes this by driving both ports in a single cycle with addresses that select the same entry. It first sets the entry's history so that the vote crosses the two-of-three threshold exactly when the new outcome is shifted in. The prediction returned for that cycle must match the vote on the old history. A following lookup must then show the vote on the new history, which proves the write was not lost.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  typedef enum logic [1:0] {
    MODE_FIXED   = 2'b00,
    MODE_STATIC  = 2'b01,
    MODE_DYNAMIC = 2'b10,
    MODE_RSVD    = 2'b11
  } bdp_mode_e;

  typedef enum logic [1:0] {
    KIND_UNCOND  = 2'b00,
    KIND_COND    = 2'b01,
    KIND_LOOP    = 2'b10,
    KIND_CALLRET = 2'b11
  } bdp_kind_e;
endpackage

// File: rtl/bdp_hist_table.sv
module bdp_hist_table #(
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  // Newest outcome enters at bit 0; the top bit (oldest) falls off.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {mem[wr_idx][HIST_W-2:0], wr_bit};
    end
  end

  // Read sees the contents before this cycle's write (old-data on collision).
  assign rd_hist = mem[rd_idx];
endmodule

// File: rtl/bdp_majority.sv
module bdp_majority #(
  parameter int HIST_W = 3
) (
  input  logic [HIST_W-1:0] hist,
  output logic              taken
);
  localparam int CNT_W  = $clog2(HIST_W + 1);
  localparam int THRESH = HIST_W / 2 + 1;

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_W; i++) ones = ones + CNT_W'(hist[i]);
  end

  assign taken = (ones >= CNT_W'(THRESH));
endmodule

// File: rtl/bdp_static_rule.sv
module bdp_static_rule
  import bdp_pkg::*;
(
  input  logic [1:0] kind,
  output logic       taken
);
  always_comb begin
    unique case (bdp_kind_e'(kind))
      KIND_COND:    taken = 1'b0;
      KIND_UNCOND,
      KIND_LOOP,
      KIND_CALLRET: taken = 1'b1;
      default:      taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bdir_predictor.sv
module bdir_predictor
  import bdp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_kind,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  output logic              pr_valid,
  output logic              pr_taken
);
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [HIST_W-1:0] lk_hist;
  logic              dyn_taken, stat_taken, next_taken;
  logic              unused_addr_bits;

  assign lk_idx = lk_addr[IDX_HI:IDX_LO];
  assign up_idx = up_addr[IDX_HI:IDX_LO];
  assign unused_addr_bits = ^{lk_addr[ADDR_W-1:IDX_HI+1], lk_addr[IDX_LO-1:0],
                              up_addr[ADDR_W-1:IDX_HI+1], up_addr[IDX_LO-1:0]};

  bdp_hist_table #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (lk_idx),
    .rd_hist(lk_hist),
    .wr_en  (up_valid),
    .wr_idx (up_idx),
    .wr_bit (up_taken)
  );

  bdp_majority #(.HIST_W(HIST_W)) u_vote (
    .hist (lk_hist),
    .taken(dyn_taken)
  );

  bdp_static_rule u_static (
    .kind (lk_kind),
    .taken(stat_taken)
  );

  always_comb begin
    case (bdp_mode_e'(mode))
      MODE_STATIC:  next_taken = stat_taken;
      MODE_DYNAMIC: next_taken = dyn_taken;
      default:      next_taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pr_valid <= 1'b0;
      pr_taken <= 1'b0;
    end else begin
      pr_valid <= lk_valid;
      pr_taken <= lk_valid & next_taken;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pr_valid && !pr_taken));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pr_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !pr_valid |-> !pr_taken);

  assert_fixed_never_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (mode == 2'b00 || mode == 2'b11)) |=> !pr_taken);

  assert_static_cond_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && mode == 2'b01 && lk_kind == 2'b01) |=> !pr_taken);

  assert_static_other_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && mode == 2'b01 && lk_kind != 2'b01) |=> pr_taken);
endmodule

// File: tb/bdir_predictor_bench.sv
module bdir_predictor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'b00;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic [1:0]  lk_kind = 2'b00;
  logic        up_valid = 1'b0;
  logic [31:0] up_addr = '0;
  logic        up_taken = 1'b0;
  logic        pr_valid, pr_taken;

  int checks = 0;
  int fails  = 0;
  logic [2:0] model [16];

  always #10 clk = ~clk;

  bdir_predictor u_bdir_predictor (
    .clk(clk), .rst(rst), .mode(mode),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_kind(lk_kind),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken),
    .pr_valid(pr_valid), .pr_taken(pr_taken)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic vote(input logic [2:0] h);
    return (int'(h[0]) + int'(h[1]) + int'(h[2])) >= 2;
  endfunction

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  // Inputs change at the falling edge; outputs are read one falling edge later.
  task automatic train(input logic [31:0] a, input logic t);
    up_valid = 1'b1; up_addr = a; up_taken = t;
    @(negedge clk);
    up_valid = 1'b0;
    model[idx_of(a)] = {model[idx_of(a)][1:0], t};
  endtask

  task automatic lookup(input logic [1:0] m, input logic [31:0] a, input logic [1:0] k,
                        input logic exp, input string tag);
    mode = m; lk_valid = 1'b1; lk_addr = a; lk_kind = k;
    @(negedge clk);
    lk_valid = 1'b0;
    check({tag, " valid"}, pr_valid, 1'b1);
    check(tag, pr_taken, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", pr_valid, 1'b0);
    check("R1 reset taken", pr_taken, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset valid", pr_valid, 1'b0);
    for (int i = 0; i < 16; i++) model[i] = 3'b000;
    for (int i = 0; i < 16; i++)
      lookup(2'b10, 32'(i * 4), 2'b00, 1'b0, "R1 cleared history R5");
  endtask

  task automatic t_idle();
    lk_valid = 1'b0;
    @(negedge clk);
    check("R2 idle valid", pr_valid, 1'b0);
    check("R2 idle taken", pr_taken, 1'b0);
  endtask

  task automatic t_fixed();
    mode = 2'b00;
    // R6: training is applied even in fixed mode
    train(32'h0000_000C, 1'b1);
    train(32'h0000_000C, 1'b1);
    train(32'h0000_000C, 1'b1);
    for (int k = 0; k < 4; k++) begin
      lookup(2'b00, 32'h0000_000C, 2'(k), 1'b0, "R3 fixed");
      lookup(2'b11, 32'h0000_000C, 2'(k), 1'b0, "R3 reserved");
    end
    lookup(2'b10, 32'h0000_000C, 2'b01, vote(model[3]), "R6 trained in fixed R5");
  endtask

  task automatic t_static();
    lookup(2'b01, 32'h0000_0010, 2'b00, 1'b1, "R4 unconditional");
    lookup(2'b01, 32'h0000_0010, 2'b01, 1'b0, "R4 conditional");
    lookup(2'b01, 32'h0000_0010, 2'b10, 1'b1, "R4 loop");
    lookup(2'b01, 32'h0000_0010, 2'b11, 1'b1, "R4 call/return");
    lookup(2'b01, 32'h0000_000C, 2'b01, 1'b0, "R4 ignores history");
  endtask

  task automatic t_dynamic();
    logic bits [6] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int s = 0; s < 6; s++) begin
      train(32'h0000_0014, bits[s]);
      lookup(2'b10, 32'h0000_0014, 2'b01, vote(model[5]), "R5 R6 shift and vote");
    end
  endtask

  task automatic t_index();
    train(32'h0000_0048, 1'b1);
    train(32'h0001_0049, 1'b1);
    lookup(2'b10, 32'h0000_000B, 2'b00, 1'b1, "R7 alias shares entry");
    lookup(2'b10, 32'hFFFF_FFCA, 2'b00, vote(model[2]), "R7 high bits ignored");
    lookup(2'b10, 32'h0000_0044, 2'b00, vote(model[1]), "R7 neighbour untouched");
    lookup(2'b10, 32'h0000_004C, 2'b00, vote(model[3]), "R7 other neighbour");
  endtask

  task automatic t_same_cycle();
    // entry 9 holds 001: one taken, so the old-history vote says not taken
    train(32'h0000_0024, 1'b1);
    mode = 2'b10; lk_valid = 1'b1; lk_addr = 32'h0000_0024; lk_kind = 2'b01;
    up_valid = 1'b1; up_addr = 32'h0000_0024; up_taken = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R8 collision uses old history (001)", pr_taken, 1'b0);
    model[9] = {model[9][1:0], 1'b1};
    lookup(2'b10, 32'h0000_0024, 2'b01, 1'b1, "R8 update kept (011)");
    train(32'h0000_0024, 1'b0);
    mode = 2'b10; lk_valid = 1'b1; lk_addr = 32'h0000_0024;
    up_valid = 1'b1; up_addr = 32'h0000_0024; up_taken = 1'b0;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    check("R8 collision uses old history (110)", pr_taken, 1'b1);
    model[9] = {model[9][1:0], 1'b0};
    lookup(2'b10, 32'h0000_0024, 2'b01, 1'b0, "R8 update kept (100)");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_fixed();
    t_static();
    t_dynamic();
    t_index();
    t_same_cycle();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule